// File: doc/BRIEF.md
# Tagged TLB Invalidation Engine

This block is a small fully associative translation cache with a built-in invalidation sequencer. Each entry carries a 16-bit virtual-processor ID, a 52-bit linear page number, a global flag and a physical page number. A fill port writes new entries. A lookup port compares an ID and page number against all valid entries in the same cycle and returns hit and the physical page.

An invalidation request carries a type code, a 128-bit descriptor and a 4-bit mask of accepted types. The sequencer captures the request and checks it in one cycle. If the check passes, it visits the entries one per cycle and clears each valid entry that meets the rule for the type. It then ends with a one-cycle done pulse, or with a one-cycle fail pulse when the check rejects the request.

The sequencer has five states. IDLE goes to CHECK when a request arrives. CHECK goes to WALK when the request is valid and to FAIL when it is not. WALK stays in WALK until the last entry has been visited and then goes to DONE. DONE and FAIL both go back to IDLE. While the sequencer is out of IDLE, the block reports itself busy.

Top module: `tlb_inval_engine`

## Requirements
- R1: When the block is idle and `lk_valid` is high, `lk_hit` is 1 if some valid entry has both the ID and the page number asked for. `lk_ppn` then gives the physical page of the lowest-numbered such entry. Otherwise `lk_hit` is 0 and `lk_ppn` is 0.
- R2: An accepted fill writes the lowest-numbered invalid entry. If no entry is invalid, it replaces the entry named by a replacement pointer. The pointer starts at 0 after reset and advances by one, wrapping after the last entry, only on such a replacement.
- R3: Type code 0 clears entries whose ID equals descriptor bits 15:0 and whose page number equals descriptor bits 127:76 (linear address bits 63:12).
- R4: Type code 1 clears every entry whose ID equals the descriptor ID.
- R5: Type code 2 clears every entry with a nonzero ID and keeps entries with ID 0.
- R6: Type code 3 clears entries whose ID equals the descriptor ID, except entries whose global flag is 1.
- R7: The context tag given with a fill has no effect on any lookup or invalidation result.
- R8: A type code above 3, or a code whose bit in `inv_types_ok` is 0 (bit n enables code n), ends in fail and leaves every entry unchanged.
- R9: A request fails with no entry changed in three cases: descriptor bits 63:16 are not all zero; the descriptor ID is 0 for type 0, 1 or 3; or, for type 0, descriptor bits 127:111 are neither all zeros nor all ones.
- R10: A request is taken only when the block is idle. `inv_fail` rises for exactly one cycle 2 cycles after the request edge. `inv_done` rises for exactly one cycle 18 cycles after it (with 16 entries). The two are never high together.
- R11: `lk_stall` is high from the cycle after a request is taken through the cycle of its done or fail pulse. While it is high, lookups return no hit, and fills and new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_valid | input | 1 | Write a new entry |
| fill_id | input | 16 | ID of the new entry |
| fill_vpn | input | 52 | Linear page number of the new entry |
| fill_global | input | 1 | Global flag of the new entry |
| fill_ctx | input | 12 | Context tag; never used for matching |
| fill_ppn | input | 40 | Physical page of the new entry |
| lk_valid | input | 1 | Lookup request |
| lk_id | input | 16 | Lookup ID |
| lk_vpn | input | 52 | Lookup page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 40 | Physical page on a hit, 0 otherwise |
| lk_stall | output | 1 | Sequencer busy; lookups and fills are stalled |
| inv_req | input | 1 | Start an invalidation |
| inv_type | input | 4 | Invalidation type code |
| inv_desc | input | 128 | Invalidation descriptor |
| inv_types_ok | input | 4 | Mask of accepted type codes |
| inv_done | output | 1 | One-cycle pulse: walk finished |
| inv_fail | output | 1 | One-cycle pulse: request rejected |

## Verification
The hardest cases to reach are fills and new requests that arrive while a walk is running, and requests that are rejected at the very moment the table holds entries they would have cleared. The stimulus fills the whole table before each invalidation, so every type rule has entries to keep and entries to clear. During the busy window it drives a fill, a lookup and a second request. After every invalidation it sweeps lookups over every ID and page combination in use, so that any entry the block should have kept, but lost, shows up as a missed hit.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
    localparam int ID_W    = 16;
    localparam int VPN_W   = 52;
    localparam int PPN_W   = 40;
    localparam int CTX_W   = 12;
    localparam int CODE_W  = 4;
    localparam int DESC_W  = 128;
    localparam int RSVD_W  = 48;
    localparam int CANON_W = 17;

    localparam logic [1:0] K_ADDR  = 2'd0;
    localparam logic [1:0] K_ID    = 2'd1;
    localparam logic [1:0] K_ALL   = 2'd2;
    localparam logic [1:0] K_KEEPG = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_WALK,
        S_DONE,
        S_FAIL
    } seq_state_t;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [VPN_W-1:0] vpn;
        logic             glob;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlbi_check.sv
module tlbi_check
    import tlbi_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    input  logic [3:0]         mask_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic [RSVD_W-1:0]  rsvd_i,
    input  logic [CANON_W-1:0] addr_top_i,
    output logic               ok_o
);
    logic code_ok, id_ok, canon_ok, rsvd_ok;

    always_comb begin
        code_ok  = (code_i < CODE_W'(4)) && mask_i[code_i[1:0]];
        rsvd_ok  = (rsvd_i == '0);
        id_ok    = (code_i[1:0] == K_ALL) || (id_i != '0);
        canon_ok = (code_i[1:0] != K_ADDR) || (addr_top_i == '0) || (&addr_top_i);
        ok_o     = code_ok && rsvd_ok && id_ok && canon_ok;
    end
endmodule

// File: rtl/tlbi_rule.sv
module tlbi_rule
    import tlbi_pkg::*;
(
    input  logic [1:0]       kind_i,
    input  logic [ID_W-1:0]  want_id_i,
    input  logic [VPN_W-1:0] want_vpn_i,
    input  logic [ID_W-1:0]  ent_id_i,
    input  logic [VPN_W-1:0] ent_vpn_i,
    input  logic             ent_glob_i,
    output logic             clear_o
);
    always_comb begin
        unique case (kind_i)
            K_ADDR:  clear_o = (ent_id_i == want_id_i) && (ent_vpn_i == want_vpn_i);
            K_ID:    clear_o = (ent_id_i == want_id_i);
            K_ALL:   clear_o = (ent_id_i != '0);
            K_KEEPG: clear_o = (ent_id_i == want_id_i) && !ent_glob_i;
            default: clear_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbi_seq.sv
module tlbi_seq
    import tlbi_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             chk_ok_i,
    output logic             accept_o,
    output logic             walk_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CHECK)
                idx_q <= '0;
            else if (state_q == S_WALK)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_i) state_d = S_CHECK;
            S_CHECK: state_d = chk_ok_i ? S_WALK : S_FAIL;
            S_WALK:  if (idx_q == LAST) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            S_FAIL:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        accept_o = (state_q == S_IDLE) && req_i;
        walk_o   = (state_q == S_WALK);
        busy_o   = (state_q != S_IDLE);
        done_o   = (state_q == S_DONE);
        fail_o   = (state_q == S_FAIL);
        idx_o    = idx_q;
    end
endmodule

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine
    import tlbi_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [ID_W-1:0]   fill_id,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic              fill_global,
    input  logic [CTX_W-1:0]  fill_ctx,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              lk_valid,
    input  logic [ID_W-1:0]   lk_id,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_stall,
    input  logic              inv_req,
    input  logic [CODE_W-1:0] inv_type,
    input  logic [DESC_W-1:0] inv_desc,
    input  logic [3:0]        inv_types_ok,
    output logic              inv_done,
    output logic              inv_fail
);
    tlb_entry_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0]   ent_valid;
    logic [IDX_W-1:0]     rr_q;

    logic [CODE_W-1:0]    req_code_q;
    logic [3:0]           req_mask_q;
    logic [ID_W-1:0]      req_id_q;
    logic [RSVD_W-1:0]    req_rsvd_q;
    logic [VPN_W-1:0]     req_vpn_q;

    logic                 accept, walk, busy, chk_ok, clr;
    logic [IDX_W-1:0]     idx;
    logic                 free_found;
    logic [IDX_W-1:0]     free_idx, victim;
    logic                 unused_bits;

    // the context tag and page offset take no part in any rule
    assign unused_bits = ^{fill_ctx, inv_desc[75:64]};

    tlbi_seq #(.ENTRIES(ENTRIES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (inv_req),
        .chk_ok_i (chk_ok),
        .accept_o (accept),
        .walk_o   (walk),
        .idx_o    (idx),
        .busy_o   (busy),
        .done_o   (inv_done),
        .fail_o   (inv_fail)
    );

    tlbi_check u_check (
        .code_i     (req_code_q),
        .mask_i     (req_mask_q),
        .id_i       (req_id_q),
        .rsvd_i     (req_rsvd_q),
        .addr_top_i (req_vpn_q[VPN_W-1 -: CANON_W]),
        .ok_o       (chk_ok)
    );

    tlbi_rule u_rule (
        .kind_i     (req_code_q[1:0]),
        .want_id_i  (req_id_q),
        .want_vpn_i (req_vpn_q),
        .ent_id_i   (ent_q[idx].id),
        .ent_vpn_i  (ent_q[idx].vpn),
        .ent_glob_i (ent_q[idx].glob),
        .clear_o    (clr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_code_q <= '0;
            req_mask_q <= '0;
            req_id_q   <= '0;
            req_rsvd_q <= '0;
            req_vpn_q  <= '0;
        end else if (accept) begin
            req_code_q <= inv_type;
            req_mask_q <= inv_types_ok;
            req_id_q   <= inv_desc[15:0];
            req_rsvd_q <= inv_desc[63:16];
            req_vpn_q  <= inv_desc[127:76];
        end
    end

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        victim = free_found ? free_idx : rr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            rr_q      <= '0;
        end else begin
            if (walk && clr)
                ent_valid[idx] <= 1'b0;
            if (fill_valid && !busy) begin
                ent_valid[victim] <= 1'b1;
                if (!free_found)
                    rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid && !busy)
            ent_q[victim] <= '{id: fill_id, vpn: fill_vpn, glob: fill_global, ppn: fill_ppn};
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_q[i].id == lk_id && ent_q[i].vpn == lk_vpn) begin
                lk_hit = 1'b1;
                lk_ppn = ent_q[i].ppn;
            end
        end
        if (!lk_valid || busy) begin
            lk_hit = 1'b0;
            lk_ppn = '0;
        end
        lk_stall = busy;
    end
endmodule

// File: rtl/tlbi_checker.sv
module tlbi_checker #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_stall,
    input logic               lk_hit,
    input logic               inv_done,
    input logic               inv_fail,
    input logic [ENTRIES-1:0] ent_valid
);
    p_pulses_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_done && inv_fail));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_done || inv_fail) |=> !(inv_done || inv_fail));

    p_pulse_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_done || inv_fail) |-> lk_stall);

    p_no_hit_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stall |-> !lk_hit);

    p_fail_keeps_table_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_fail |-> (ent_valid == $past(ent_valid)));

    p_no_fill_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_stall) |-> ((ent_valid & ~$past(ent_valid)) == '0));
endmodule

bind tlb_inval_engine tlbi_checker #(.ENTRIES(ENTRIES)) u_tlbi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_stall  (lk_stall),
    .lk_hit    (lk_hit),
    .inv_done  (inv_done),
    .inv_fail  (inv_fail),
    .ent_valid (ent_valid)
);

// File: tb/tb_tlb_inval_engine.sv
`timescale 1ns/1ps
module tb_tlb_inval_engine;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fill_valid = 1'b0;
    logic [15:0]  fill_id = '0;
    logic [51:0]  fill_vpn = '0;
    logic         fill_global = 1'b0;
    logic [11:0]  fill_ctx = '0;
    logic [39:0]  fill_ppn = '0;
    logic         lk_valid = 1'b0;
    logic [15:0]  lk_id = '0;
    logic [51:0]  lk_vpn = '0;
    logic         lk_hit;
    logic [39:0]  lk_ppn;
    logic         lk_stall;
    logic         inv_req = 1'b0;
    logic [3:0]   inv_type = '0;
    logic [127:0] inv_desc = '0;
    logic [3:0]   inv_types_ok = 4'hF;
    logic         inv_done, inv_fail;

    always #2.5 clk = ~clk;

    tlb_inval_engine dut (.*);

    // behavioural reference
    bit          m_v   [N];
    int          m_id  [N];
    logic [51:0] m_vpn [N];
    bit          m_g   [N];
    logic [39:0] m_ppn [N];
    int          m_rr;
    int          m_cnt;
    bit          m_ok;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    function automatic bit req_valid(int code, logic [127:0] d, logic [3:0] mask);
        logic [63:0] la = d[127:64];
        if (code > 3) return 0;
        if (!mask[code]) return 0;
        if (d[63:16] != 0) return 0;
        if (code != 2 && d[15:0] == 0) return 0;
        if (code == 0 && !(la[63:47] == 17'h0 || la[63:47] == 17'h1FFFF)) return 0;
        return 1;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_rr = 0; m_cnt = 0; m_ok = 0;
            return;
        end
        if (m_cnt > 0) begin
            m_cnt--;
            return;
        end
        if (fill_valid) begin
            int slot = -1;
            for (int i = 0; i < N; i++) if (!m_v[i] && slot < 0) slot = i;
            if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
            m_v[slot] = 1; m_id[slot] = fill_id; m_vpn[slot] = fill_vpn;
            m_g[slot] = fill_global; m_ppn[slot] = fill_ppn;
        end
        if (inv_req) begin
            m_ok  = req_valid(inv_type, inv_desc, inv_types_ok);
            m_cnt = m_ok ? N + 2 : 2;
            if (m_ok) begin
                int code = inv_type;
                for (int i = 0; i < N; i++) begin
                    bit kill;
                    case (code)
                        0: kill = (m_id[i] == inv_desc[15:0]) && (m_vpn[i] == inv_desc[127:76]);
                        1: kill = (m_id[i] == inv_desc[15:0]);
                        2: kill = (m_id[i] != 0);
                        default: kill = (m_id[i] == inv_desc[15:0]) && !m_g[i];
                    endcase
                    if (kill) m_v[i] = 0;
                end
            end
        end
    endtask

    task automatic check1(string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_hit = 0;
        logic [39:0] e_ppn = '0;
        if (rst_n && m_cnt == 0 && lk_valid)
            for (int i = N - 1; i >= 0; i--)
                if (m_v[i] && m_id[i] == lk_id && m_vpn[i] == lk_vpn) begin
                    e_hit = 1; e_ppn = m_ppn[i];
                end
        check1("lk_hit (R1)", 64'(lk_hit), 64'(e_hit));
        check1("lk_ppn (R1)", 64'(lk_ppn), 64'(e_ppn));
        check1("lk_stall (R11)", 64'(lk_stall), 64'(m_cnt > 0));
        check1("inv_done (R10)", 64'(inv_done), 64'(m_cnt == 1 && m_ok));
        check1("inv_fail (R10)", 64'(inv_fail), 64'(m_cnt == 1 && !m_ok));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic do_fill(int id, int vpn, bit g, int ctx, int ppn);
        fill_valid = 1; fill_id = 16'(id); fill_vpn = 52'(vpn);
        fill_global = g; fill_ctx = 12'(ctx); fill_ppn = 40'(ppn);
        tick();
        fill_valid = 0;
    endtask

    task automatic do_look(int id, int vpn);
        lk_valid = 1; lk_id = 16'(id); lk_vpn = 52'(vpn);
        tick();
        lk_valid = 0;
    endtask

    task automatic sweep();
        string keep = tag;
        tag = {keep, "/R1"};
        for (int id = 0; id < 4; id++)
            for (int v = 0; v < 20; v++) do_look(id, v);
        tag = keep;
    endtask

    function automatic logic [127:0] mk_desc(logic [63:0] la, logic [47:0] rsvd, int id);
        return {la, rsvd, 16'(id)};
    endfunction

    // issue a request; while busy, try a fill, a lookup and a second request (R11)
    task automatic do_inv(int code, logic [127:0] d, logic [3:0] mask);
        inv_req = 1; inv_type = 4'(code); inv_desc = d; inv_types_ok = mask;
        tick();
        inv_req = 0;
        tick();
        fill_valid = 1; fill_id = 16'd1; fill_vpn = 52'd19; fill_ppn = 40'hBAD;
        lk_valid = 1; lk_id = 16'd1; lk_vpn = 52'd1;
        inv_req = 1; inv_type = 4'd2;
        tick();
        fill_valid = 0; lk_valid = 0; inv_req = 0;
        while (m_cnt > 0) tick();
        inv_types_ok = 4'hF;
    endtask

    task automatic fill_table();
        for (int i = 0; i < N; i++) do_fill(i % 4, i, (i % 3) == 0, i, 100 + i);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tag = "R1 reset";
        lk_valid = 1; lk_id = 0; lk_vpn = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        lk_valid = 0;

        tag = "R2";
        fill_table();
        do_fill(3, 16, 0, 0, 200);
        do_fill(2, 17, 1, 0, 201);
        do_fill(1, 18, 0, 0, 202);
        sweep();

        tag = "R3";
        do_inv(0, mk_desc(64'(5) << 12, 0, 1), 4'hF);
        sweep();

        tag = "R4";
        do_inv(1, mk_desc(0, 0, 2), 4'hF);
        sweep();

        tag = "R6";
        fill_table();
        do_inv(3, mk_desc(0, 0, 3), 4'hF);
        sweep();

        tag = "R5";
        fill_table();
        do_inv(2, mk_desc(0, 0, 0), 4'hF);
        sweep();

        tag = "R7";
        do_fill(1, 7, 0, 12'h5A5, 300);
        do_fill(1, 8, 0, 12'hFFF, 301);
        do_inv(1, mk_desc(0, 0, 1), 4'hF);
        sweep();

        tag = "R8";
        fill_table();
        do_inv(5, mk_desc(0, 0, 1), 4'hF);
        do_inv(1, mk_desc(0, 0, 1), 4'b1101);
        do_inv(3, mk_desc(0, 0, 3), 4'b0111);
        sweep();

        tag = "R9";
        do_inv(1, mk_desc(0, 48'h1, 1), 4'hF);
        do_inv(2, mk_desc(0, 48'h8000_0000_0000, 0), 4'hF);
        do_inv(1, mk_desc(0, 0, 0), 4'hF);
        do_inv(0, mk_desc(64'h0000_8000_0000_3000, 0, 3), 4'hF);
        sweep();
        do_inv(0, mk_desc(64'(4) << 12, 0, 0), 4'hF);
        sweep();

        tag = "R10 R11 mixed";
        for (int k = 0; k < 300; k++) begin
            int op = $urandom % 10;
            if (op < 4) do_fill($urandom % 4, $urandom % 20, $urandom % 2, $urandom, $urandom % 1000);
            else if (op < 8) do_look($urandom % 4, $urandom % 20);
            else begin
                logic [47:0] rs = ($urandom % 8 == 0) ? 48'h10 : 48'h0;
                do_inv($urandom % 5, mk_desc(64'($urandom % 20) << 12, rs, $urandom % 4),
                       4'($urandom));
            end
        end
        sweep();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule